// File: doc/BRIEF.md
# Debug Sleep Handshake Controller

This block coordinates a low-power sleep transition between the on-chip device and an external debug tool. The device raises a sleep request or a wake request. The tool sees a single synchronization bit in a small control register and answers by writing that bit. When the tool has acknowledged, the block issues a one-cycle sleep-enter grant or a one-cycle sleep-exit grant. The control register also holds a low-power debug enable field. While that field is 0, the tool plays no part: sleep and wake requests are granted directly.

The sync bit carries a two-phase handshake, and its meaning flips between phases. On the way into sleep, the device raises the bit and the tool clears it to grant entry. On the way out, the bit is already 0 and the tool writes a 1 to grant exit. That write is consumed by the handshake, so the bit never reads back as 1 afterwards. Clock gating, power domains and the debug transport are outside this block.

Top module: `dbg_sleep_hs`

## Requirements
- R1: After a synchronous active-high reset, the register reads all zeros, both grants are 0, and the handshake is idle.
- R2: Bit 0 of the control register is the low-power debug enable and bit 1 is the sync bit; every other bit reads 0. Every write stores bit 0 of the written data as the enable, and the new value reads back in the cycle after the write.
- R3: With the enable at 0, a sleep request in idle asserts the enter grant in the next cycle and leaves the sync bit at 0. A later wake request asserts the exit grant in the next cycle.
- R4: With the enable at 1, a sleep request in idle sets the sync bit to 1 in the next cycle and raises no grant.
- R5: While entry is pending, a tool write with sync bit 0 asserts the enter grant in the next cycle, and the sync bit then reads 0.
- R6: With the enable at 1, a wake request while asleep keeps the sync bit at 0 and raises no grant. A tool write with sync bit 1 then asserts the exit grant in the next cycle, and the sync bit still reads 0.
- R7: A tool write of the wrong polarity changes neither the sync bit nor any grant. This covers a write of 1 while entry is pending, a write of 0 while exit is pending, and any write of the sync bit while idle or asleep.
- R8: A wake request while entry is pending cancels the entry: the sync bit reads 0 in the next cycle, no enter grant is issued, and the block is idle again. The wake request wins over a tool write in the same cycle.
- R9: Each grant lasts exactly one cycle, and the two grants are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_sleep_req | input | 1 | Device asks to enter sleep |
| dev_wake_req | input | 1 | Device asks to leave sleep |
| reg_wr_en | input | 1 | Tool write strobe for the control register |
| reg_wr_data | input | CTRL_W | Tool write data |
| reg_rd_data | output | CTRL_W | Control register read-back |
| sleep_enter_grant | output | 1 | One-cycle grant to enter sleep |
| sleep_exit_grant | output | 1 | One-cycle grant to leave sleep |

## Verification
The assertions assume that the device raises a sleep request only from idle and a wake request only when asleep or when cancelling a pending entry. They also assume that every request and write lasts exactly one cycle. The directed tasks drive each request and each write for one cycle at a time, at the falling edge, and return to quiet inputs between steps. The bench also deliberately sends writes of the wrong polarity and a write in the same cycle as a wake request, because the block defines how it handles both.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTRY_PEND,
        ST_ASLEEP,
        ST_EXIT_PEND
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
        logic      sync;
        logic      enter_gnt;
        logic      exit_gnt;
    } hs_regs_t;
endpackage

// File: rtl/dsh_ctrl_reg.sv
module dsh_ctrl_reg #(
    parameter int CTRL_W   = 8,
    parameter int EN_POS   = 0,
    parameter int SYNC_POS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              en,
    output logic              tool_set,
    output logic              tool_clr
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_en) en_d = wr_data[EN_POS];
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_d;
    end

    // every write carries a sync value: decode it into a set or clear strobe
    assign en       = en_q;
    assign tool_set = wr_en &  wr_data[SYNC_POS];
    assign tool_clr = wr_en & ~wr_data[SYNC_POS];
endmodule

// File: rtl/dsh_fsm.sv
module dsh_fsm
    import dsh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      sleep_req,
    input  logic      wake_req,
    input  logic      tool_set,
    input  logic      tool_clr,
    output hs_state_e state,
    output logic      sync,
    output logic      enter_gnt,
    output logic      exit_gnt
);
    hs_regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.enter_gnt = 1'b0;
        r_d.exit_gnt  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (sleep_req) begin
                    if (en) begin
                        r_d.state = ST_ENTRY_PEND;
                        r_d.sync  = 1'b1;
                    end else begin
                        r_d.state     = ST_ASLEEP;
                        r_d.enter_gnt = 1'b1;
                    end
                end
            end
            ST_ENTRY_PEND: begin
                if (wake_req) begin
                    r_d.state = ST_IDLE;
                    r_d.sync  = 1'b0;
                end else if (tool_clr) begin
                    r_d.state     = ST_ASLEEP;
                    r_d.sync      = 1'b0;
                    r_d.enter_gnt = 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (wake_req) begin
                    r_d.sync = 1'b0;
                    if (en) begin
                        r_d.state = ST_EXIT_PEND;
                    end else begin
                        r_d.state    = ST_IDLE;
                        r_d.exit_gnt = 1'b1;
                    end
                end
            end
            ST_EXIT_PEND: begin
                if (tool_set) begin
                    r_d.state    = ST_IDLE;
                    r_d.exit_gnt = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state     <= ST_IDLE;
            r_q.sync      <= 1'b0;
            r_q.enter_gnt <= 1'b0;
            r_q.exit_gnt  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.state;
    assign sync      = r_q.sync;
    assign enter_gnt = r_q.enter_gnt;
    assign exit_gnt  = r_q.exit_gnt;
endmodule

// File: rtl/dbg_sleep_hs.sv
module dbg_sleep_hs
    import dsh_pkg::*;
#(
    parameter int CTRL_W   = 8,
    parameter int EN_POS   = 0,
    parameter int SYNC_POS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_sleep_req,
    input  logic              dev_wake_req,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wr_data,
    output logic [CTRL_W-1:0] reg_rd_data,
    output logic              sleep_enter_grant,
    output logic              sleep_exit_grant
);
    logic      lpd_en, tool_set, tool_clr, sync_bit;
    hs_state_e hs_state;

    dsh_ctrl_reg #(.CTRL_W(CTRL_W), .EN_POS(EN_POS), .SYNC_POS(SYNC_POS)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .en      (lpd_en),
        .tool_set(tool_set),
        .tool_clr(tool_clr)
    );

    dsh_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (lpd_en),
        .sleep_req(dev_sleep_req),
        .wake_req (dev_wake_req),
        .tool_set (tool_set),
        .tool_clr (tool_clr),
        .state    (hs_state),
        .sync     (sync_bit),
        .enter_gnt(sleep_enter_grant),
        .exit_gnt (sleep_exit_grant)
    );

    for (genvar i = 0; i < CTRL_W; i++) begin : g_rd
        if (i == EN_POS) begin : g_en
            assign reg_rd_data[i] = lpd_en;
        end else if (i == SYNC_POS) begin : g_sync
            assign reg_rd_data[i] = sync_bit;
        end else begin : g_zero
            assign reg_rd_data[i] = 1'b0;
        end
    end
endmodule

// File: rtl/dsh_checker.sv
module dsh_checker
    import dsh_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sleep_req,
    input logic      wake_req,
    input logic      wr_en,
    input logic      wr_sync,
    input logic      en,
    input logic      sync,
    input hs_state_e state,
    input logic      enter_gnt,
    input logic      exit_gnt
);
    // R1: after reset, idle with sync low and no grant
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (state == ST_IDLE && !sync && !enter_gnt && !exit_gnt));

    // R3: bypass path grants entry directly
    p_bypass_enter_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && sleep_req && !en) |=> (enter_gnt && !sync));

    // R4: enabled sleep request raises sync
    p_sync_raise_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && sleep_req && en) |=> (sync && !enter_gnt));

    // R5: tool clear during pending entry grants entry
    p_enter_on_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (sync && wr_en && !wr_sync && !wake_req) |=> (enter_gnt && !sync));

    // R6: exit grant never exposes a set sync bit
    p_exit_sync_low_r6: assert property (@(posedge clk) disable iff (rst)
        exit_gnt |-> !sync);

    // R8: wake during pending entry cancels without grant
    p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
        (sync && wake_req) |=> (!sync && !enter_gnt && state == ST_IDLE));

    // R9: one-cycle grants, never together
    p_enter_pulse_r9: assert property (@(posedge clk) disable iff (rst) enter_gnt |=> !enter_gnt);
    p_exit_pulse_r9:  assert property (@(posedge clk) disable iff (rst) exit_gnt |=> !exit_gnt);
    p_grant_excl_r9:  assert property (@(posedge clk) disable iff (rst) !(enter_gnt && exit_gnt));
endmodule

bind dbg_sleep_hs dsh_checker u_dsh_checker (
    .clk      (clk),
    .rst      (rst),
    .sleep_req(dev_sleep_req),
    .wake_req (dev_wake_req),
    .wr_en    (reg_wr_en),
    .wr_sync  (reg_wr_data[SYNC_POS]),
    .en       (lpd_en),
    .sync     (sync_bit),
    .state    (hs_state),
    .enter_gnt(sleep_enter_grant),
    .exit_gnt (sleep_exit_grant)
);

// File: tb/test_dbg_sleep_hs.sv
module test_dbg_sleep_hs;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sreq = 1'b0, wreq = 1'b0, we = 1'b0;
    logic [W-1:0] wd = '0;
    logic [W-1:0] rd;
    logic         eg, xg;
    int           n_chk = 0, n_err = 0;

    always #10 clk = ~clk;  // 50 MHz

    dbg_sleep_hs #(.CTRL_W(W)) i_dbg_sleep_hs (
        .clk(clk), .rst(rst), .dev_sleep_req(sreq), .dev_wake_req(wreq),
        .reg_wr_en(we), .reg_wr_data(wd), .reg_rd_data(rd),
        .sleep_enter_grant(eg), .sleep_exit_grant(xg)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus at the falling edge, return at the next falling edge
    task automatic cyc(input logic s, input logic w, input logic e, input logic [W-1:0] d);
        sreq = s; wreq = w; we = e; wd = d;
        @(negedge clk);
        sreq = 0; wreq = 0; we = 0; wd = '0;
    endtask

    task automatic expect_out(input string req, input logic [W-1:0] r, input logic g_en, input logic g_ex);
        chk(req, rd, r);
        chk(req, {7'd0, eg}, {7'd0, g_en});
        chk(req, {7'd0, xg}, {7'd0, g_ex});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1 reset", 8'h00, 0, 0);
        cyc(0, 0, 1, 8'h01);
        cyc(1, 0, 0, 8'h00);
        do_reset();
        expect_out("R1 reset mid-handshake", 8'h00, 0, 0);
    endtask

    task automatic t_enable_rw();
        do_reset();
        cyc(0, 0, 1, 8'hFD);
        expect_out("R2 enable set, other bits zero", 8'h01, 0, 0);
        cyc(0, 0, 1, 8'hFC);
        expect_out("R2 enable cleared", 8'h00, 0, 0);
    endtask

    task automatic t_bypass();
        do_reset();
        cyc(1, 0, 0, 8'h00);
        expect_out("R3 direct enter grant", 8'h00, 1, 0);
        cyc(0, 0, 0, 8'h00);
        expect_out("R9 enter grant one cycle", 8'h00, 0, 0);
        cyc(0, 1, 0, 8'h00);
        expect_out("R3 direct exit grant", 8'h00, 0, 1);
        cyc(0, 0, 0, 8'h00);
        expect_out("R9 exit grant one cycle", 8'h00, 0, 0);
    endtask

    task automatic t_handshake();
        do_reset();
        cyc(0, 0, 1, 8'h01);
        cyc(1, 0, 0, 8'h00);
        expect_out("R4 sync raised", 8'h03, 0, 0);
        cyc(0, 0, 1, 8'h01);
        expect_out("R5 enter grant on clear", 8'h01, 1, 0);
        cyc(0, 0, 0, 8'h00);
        expect_out("R9 enter pulse ends", 8'h01, 0, 0);
        cyc(0, 1, 0, 8'h00);
        expect_out("R6 wake waits for tool", 8'h01, 0, 0);
        cyc(0, 0, 0, 8'h00);
        expect_out("R6 still waiting", 8'h01, 0, 0);
        cyc(0, 0, 1, 8'h03);
        expect_out("R6 exit grant, sync reads 0", 8'h01, 0, 1);
        cyc(0, 0, 0, 8'h00);
        expect_out("R9 exit pulse ends", 8'h01, 0, 0);
    endtask

    task automatic t_wrong_polarity();
        do_reset();
        cyc(0, 0, 1, 8'h03);
        expect_out("R7 sync write in idle ignored", 8'h01, 0, 0);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h03);
        expect_out("R7 set while entry pending ignored", 8'h03, 0, 0);
        cyc(0, 0, 1, 8'h01);
        expect_out("R5 entry after ignored write", 8'h01, 1, 0);
        cyc(0, 0, 1, 8'h03);
        expect_out("R7 set while asleep ignored", 8'h01, 0, 0);
        cyc(0, 1, 0, 8'h00);
        cyc(0, 0, 1, 8'h01);
        expect_out("R7 clear while exit pending ignored", 8'h01, 0, 0);
        cyc(0, 0, 1, 8'h03);
        expect_out("R6 exit after ignored write", 8'h01, 0, 1);
    endtask

    task automatic t_cancel();
        do_reset();
        cyc(0, 0, 1, 8'h01);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 1, 0, 8'h00);
        expect_out("R8 cancel clears sync", 8'h01, 0, 0);
        cyc(0, 0, 1, 8'h01);
        expect_out("R8 idle after cancel, no grant", 8'h01, 0, 0);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 1, 1, 8'h01);
        expect_out("R8 wake beats same-cycle clear", 8'h01, 0, 0);
        cyc(1, 0, 0, 8'h00);
        expect_out("R8 new entry after cancel", 8'h03, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_bypass();
        t_handshake();
        t_wrong_polarity();
        t_cancel();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule